// File: doc/BRIEF.md
# Ping-pong LIFO segment reverser

This block sits on the reverse data path of a symmetric FIR filter and turns the order of incoming samples around in short segments. It holds two last-in-first-out banks. One bank collects the current segment while the other bank plays out the previous segment, newest sample first. A transfer strobe marks the segment boundaries. On each high-to-low transition of the strobe the two banks swap roles. When the filter decimates by N, the strobe goes low once every N clocks, so every segment is N samples long.

A reversal enable selects the mode. With reversal off, the block acts as a plain one-clock delay register and keeps the sample order. Reversal must be off while interleaved data passes through the filter. With reversal on, the incoming sample is written on every clock. The sample that arrives in the same clock as the strobe's falling edge is the first sample of the new segment. Each channel of a filter uses its own instance, so each channel has its own enable bit.

Top module: `pingPongReverser`

## Requirements
- R1: After the synchronous reset `sampleOut` is 0, bank A is the collecting bank, and `sampleOut` stays 0 until the first strobe falling edge.
- R2: The banks swap only when `xferStrobe` is sampled low at a rising clock edge and was sampled high at the edge before. Holding the strobe low keeps the same bank collecting and causes no further swaps.
- R3: Samples s0..s(k-1) are collected in the clocks before a swap clock. At the edge of the swap clock and at the k-1 edges that follow, `sampleOut` shows s(k-1), s(k-2), ..., s0, one sample per edge.
- R4: When the strobe is low for one clock in every N (2 ≤ N ≤ DEPTH), each segment of N samples comes out fully reversed during the next N clocks, with no gap and no overlap.
- R5: While reversal is on and the playing bank holds no more entries, `sampleOut` is 0.
- R6: With `revEnable` low, `sampleOut` equals the `sampleIn` of the previous clock, whatever the strobe does.
- R7: A bank keeps at most DEPTH (default 16) samples. Samples that arrive after the bank is full are dropped, and only the first DEPTH samples of the segment are played back in reverse.
- R8: While reversal is off, both banks are emptied and bank A becomes the collecting bank. After reversal is turned back on, `sampleOut` stays 0 until the first swap, and then plays back only the samples received since reversal was re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 12 | Incoming sample |
| xferStrobe | input | 1 | Segment strobe; a falling edge swaps the banks |
| revEnable | input | 1 | 1 = reversal mode, 0 = one-clock delay mode |
| sampleOut | output | 12 | Registered output sample |

## Verification
Every result appears at the first rising edge after the clock that causes it. The first reversed sample appears at the edge that samples the strobe low. In delay mode, the output shows the input one edge after that input is sampled. The bench drives inputs on falling edges. It reads `sampleOut` on the following falling edge, so each read falls half a period after the edge that produced the value. The expected sample is computed as a function of the segment number and the position within the segment, taken N-1-m for output slot m. Slots past the stored length are expected to be 0.

// File: rtl/pprPkg.sv
package pprPkg;

  // Per-cycle command from control to datapath
  typedef struct packed {
    logic wrEn;      // store sampleIn into the collecting bank
    logic wrBank;    // 0 = bank A, 1 = bank B
    logic rdValid;   // playing bank still holds an entry this cycle
    logic rdBank;    // bank being played out
    logic passMode;  // reversal disabled: plain delay
  } pprCmd_t;

endpackage

// File: rtl/pprCtrl.sv
module pprCtrl
  import pprPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xferStrobe,
  input  logic             revEnable,
  output pprCmd_t          cmd,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx
);

  logic             strobePrev;
  logic             wrSel;
  logic [CNT_W-1:0] wrCnt;
  logic [CNT_W-1:0] rdCnt;

  logic             wrSelNext;
  logic [CNT_W-1:0] wrCntNext;
  logic [CNT_W-1:0] rdCntNext;
  logic             swapNow;
  logic             bankFull;

  assign swapNow  = revEnable && strobePrev && !xferStrobe;
  assign bankFull = (wrCnt >= CNT_W'(DEPTH));

  always_comb begin
    cmd          = '0;
    cmd.passMode = !revEnable;
    wrIdx        = '0;
    rdIdx        = '0;
    wrSelNext    = wrSel;
    wrCntNext    = wrCnt;
    rdCntNext    = rdCnt;
    if (!revEnable) begin
      wrSelNext = 1'b0;
      wrCntNext = '0;
      rdCntNext = '0;
    end else if (swapNow) begin
      // new segment starts in the other bank; old collecting bank plays out
      cmd.wrEn    = 1'b1;
      cmd.wrBank  = !wrSel;
      wrIdx       = '0;
      cmd.rdBank  = wrSel;
      cmd.rdValid = (wrCnt != '0);
      rdIdx       = IDX_W'(wrCnt - CNT_W'(1));
      wrSelNext   = !wrSel;
      wrCntNext   = CNT_W'(1);
      rdCntNext   = (wrCnt == '0) ? '0 : wrCnt - CNT_W'(1);
    end else begin
      cmd.wrEn    = !bankFull;
      cmd.wrBank  = wrSel;
      wrIdx       = IDX_W'(wrCnt);
      cmd.rdBank  = !wrSel;
      cmd.rdValid = (rdCnt != '0);
      rdIdx       = IDX_W'(rdCnt - CNT_W'(1));
      wrCntNext   = bankFull ? wrCnt : wrCnt + CNT_W'(1);
      rdCntNext   = (rdCnt == '0) ? '0 : rdCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobePrev <= 1'b0;
      wrSel      <= 1'b0;
      wrCnt      <= '0;
      rdCnt      <= '0;
    end else begin
      strobePrev <= xferStrobe;
      wrSel      <= wrSelNext;
      wrCnt      <= wrCntNext;
      rdCnt      <= rdCntNext;
    end
  end

  // R2: a sampled falling edge in reversal mode always flips the collecting bank
  p_swap_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (revEnable && strobePrev && !xferStrobe) |=> (wrSel != $past(wrSel)));

  // R2: without a falling edge the collecting bank holds
  p_no_swap_r2: assert property (@(posedge clk) disable iff (rst)
    (revEnable && !(strobePrev && !xferStrobe)) |=> $stable(wrSel));

  // R7: fill count never exceeds bank depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (wrCnt <= CNT_W'(DEPTH)) && (rdCnt <= CNT_W'(DEPTH)));

  // R3: consecutive reads inside a segment walk down by one entry
  p_rd_order_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd.rdValid && !swapNow && revEnable && $past(cmd.rdValid) && $past(revEnable))
      |-> (rdIdx == $past(rdIdx) - IDX_W'(1)));

  // R8: delay mode leaves both banks empty
  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    !revEnable |=> (wrCnt == '0 && rdCnt == '0 && wrSel == 1'b0));

endmodule

// File: rtl/pprData.sv
module pprData
  import pprPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  pprCmd_t           cmd,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] sampleOut
);

  logic [1:0][DATA_W-1:0] bankRd;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (cmd.wrEn && (cmd.wrBank == 1'(g)))
        mem[wrIdx] <= sampleIn;
    end

    assign bankRd[g] = mem[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (rst)
      sampleOut <= '0;
    else if (cmd.passMode)
      sampleOut <= sampleIn;
    else if (cmd.rdValid)
      sampleOut <= bankRd[cmd.rdBank];
    else
      sampleOut <= '0;
  end

  // R6: delay mode reproduces the previous input
  p_pass_delay_r6: assert property (@(posedge clk) disable iff (rst)
    cmd.passMode |=> (sampleOut == $past(sampleIn)));

  // R5: nothing left to play gives a zero output
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!cmd.passMode && !cmd.rdValid) |=> (sampleOut == '0));

  // never write and read the same bank in one cycle
  p_bank_split_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd.wrEn && cmd.rdValid) |-> (cmd.wrBank != cmd.rdBank));

endmodule

// File: rtl/pingPongReverser.sv
module pingPongReverser
  import pprPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              xferStrobe,
  input  logic              revEnable,
  output logic [DATA_W-1:0] sampleOut
);

  pprCmd_t          cmd;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  pprCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .xferStrobe (xferStrobe),
    .revEnable  (revEnable),
    .cmd        (cmd),
    .wrIdx      (wrIdx),
    .rdIdx      (rdIdx)
  );

  pprData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data_i (
    .clk       (clk),
    .rst       (rst),
    .sampleIn  (sampleIn),
    .cmd       (cmd),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .sampleOut (sampleOut)
  );

endmodule

// File: tb/pingPongReverser_tb.sv
module pingPongReverser_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sampleIn = '0;
  logic        xferStrobe = 1'b0;
  logic        revEnable = 1'b1;
  logic [11:0] sampleOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pingPongReverser #(.DATA_W(12), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .sampleIn(sampleIn),
    .xferStrobe(xferStrobe), .revEnable(revEnable), .sampleOut(sampleOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] smp(int n, int j, int i);
    return 12'((n * 151 + j * 37 + i * 5 + 1) & 12'hFFF);
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(logic [11:0] d, logic s, logic e);
    sampleIn   = d;
    xferStrobe = s;
    revEnable  = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) step(12'h000, 1'b0, 1'b1);
    rst = 1'b0;
  endtask

  task automatic runSweep(int n);
    int lim;
    lim = (n < DEPTH) ? n : DEPTH;
    doReset();
    step(12'h000, 1'b1, 1'b1);
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < n; i++) begin
        step(smp(n, j, i), (i != 0), 1'b1);
        if (j >= 1) begin
          if (i < lim)
            chk((n > DEPTH) ? "R7" : "R4", sampleOut, smp(n, j - 1, lim - 1 - i));
          else
            chk("R7", sampleOut, 12'h000);
        end
      end
    end
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R1: reset state
    chk("R1", sampleOut, 12'h000);

    // R1/R5: single idle sample then swap
    step(12'h0AB, 1'b1, 1'b1);
    chk("R1", sampleOut, 12'h000);
    step(12'h111, 1'b0, 1'b1);
    chk("R3", sampleOut, 12'h0AB);
    step(12'h222, 1'b0, 1'b1);
    chk("R5", sampleOut, 12'h000);

    // R2: strobe held low, no swaps; bank B keeps collecting
    for (int k = 0; k < 10; k++) begin
      step(12'(12'h300 + k), 1'b0, 1'b1);
      chk("R2", sampleOut, 12'h000);
    end
    step(12'h3FF, 1'b1, 1'b1);
    chk("R2", sampleOut, 12'h000);
    // collected: 111,222,300..309,3FF (13 samples)
    step(12'h555, 1'b0, 1'b1);
    chk("R3", sampleOut, 12'h3FF);
    for (int k = 9; k >= 0; k--) begin
      step(12'h555, 1'b1, 1'b1);
      chk("R3", sampleOut, 12'(12'h300 + k));
    end
    step(12'h555, 1'b1, 1'b1);
    chk("R3", sampleOut, 12'h222);
    step(12'h555, 1'b1, 1'b1);
    chk("R3", sampleOut, 12'h111);
    step(12'h555, 1'b1, 1'b1);
    chk("R5", sampleOut, 12'h000);

    // R6: delay mode with a toggling strobe
    for (int k = 0; k < 24; k++) begin
      logic [11:0] d;
      d = 12'((k * 397 + 11) & 12'hFFF);
      step(d, k[0], 1'b0);
      chk("R6", sampleOut, d);
    end

    // R8: re-enable, old content gone
    step(12'hA01, 1'b1, 1'b1);
    chk("R8", sampleOut, 12'h000);
    step(12'hA02, 1'b1, 1'b1);
    chk("R8", sampleOut, 12'h000);
    step(12'hA03, 1'b0, 1'b1);
    chk("R8", sampleOut, 12'hA02);
    step(12'hA04, 1'b1, 1'b1);
    chk("R8", sampleOut, 12'hA01);
    step(12'hA05, 1'b1, 1'b1);
    chk("R8", sampleOut, 12'h000);

    // R4 sweep over segment lengths, R7 with an oversize segment
    for (int n = 2; n <= DEPTH; n++) runSweep(n);
    runSweep(DEPTH + 4);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule